// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Controller

This block holds a byte-wide volatile SRAM array and a nonvolatile shadow copy of the same size, and it moves whole images between them. A STORE copies every SRAM byte into the shadow. A RECALL copies every shadow byte back into the SRAM. Three events request a STORE: a rising power-fail indication, a software strobe, or an outside device pulling the shared busy line low. Two events request a RECALL: the power-up that follows reset, and a software strobe. The software command decode is done outside the block, so each command arrives as a one-cycle strobe.

The user side is an asynchronous-style byte bus, modelled synchronously. It has active-low select, write and output-enable inputs, an address and a data bus, and the tri-state data driver is expressed as an output-enable flag. While a transfer runs, the block pulls the busy line low and locks out every user access. Requests that arrive during a transfer are held and served in turn. A pending STORE is always served before a pending RECALL. The array depth is set by `ADDR_W`: 15 gives the full 32K-byte part, and the default of 10 keeps elaboration small.

Top module: `nvshadow_ram`

## Requirements
- R1: After reset is released, a RECALL starts on its own at the next clock edge. While reset is held, the busy drive, the data output enable and the done flag are all low.
- R2: While idle and with the busy line high, select=0 with write=0 stores `dq_i` at `addr_i` on the clock edge. Select=0 with write=1 and output enable=0 sets `dq_oe_o`=1, and `dq_o` shows the stored byte in the same cycle.
- R3: `dq_oe_o` is 0 whenever the select input is 1 or the output-enable input is 1.
- R4: A STORE copies all 2^ADDR_W bytes from the SRAM to the shadow, in ascending address order, one byte per clock. It lasts exactly 2^ADDR_W cycles.
- R5: A RECALL copies all 2^ADDR_W bytes from the shadow to the SRAM and replaces any user data written since. It also lasts 2^ADDR_W cycles.
- R6: A STORE request is latched on any of three events: a 0-to-1 change of `pwr_fail_i`, a `sw_store_i` strobe, or a high-to-low change of `busy_n_i` that the block is not causing itself. A RECALL request is latched on a `sw_recall_i` strobe. The transfer starts on the edge after the request is latched.
- R7: `busy_drv_o` (1 = pull the shared busy line low) is 1 in every cycle of a transfer and 0 when idle.
- R8: During a transfer, user writes do not change the SRAM and `dq_oe_o` stays 0.
- R9: A STORE requested while a RECALL runs is held. It starts on the clock edge right after the RECALL's done cycle.
- R10: When a STORE and a RECALL are both pending at the same time, the STORE runs first and the RECALL runs after it.
- R11: `done_o` is high for exactly one cycle. That cycle is the first idle cycle after the last byte of a transfer.
- R12: While the busy line is held low from outside, user writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; its release marks power-up |
| pwr_fail_i | input | 1 | Power-fail indication; a rising edge requests a STORE |
| sw_store_i | input | 1 | One-cycle software STORE strobe |
| sw_recall_i | input | 1 | One-cycle software RECALL strobe |
| busy_n_i | input | 1 | Sensed level of the shared open-drain busy line (low = busy) |
| busy_drv_o | output | 1 | 1 = pull the shared busy line low |
| ce_n_i | input | 1 | Active-low select |
| we_n_i | input | 1 | Active-low write |
| oe_n_i | input | 1 | Active-low output enable |
| addr_i | input | ADDR_W | Byte address |
| dq_i | input | DATA_W | Write data |
| dq_o | output | DATA_W | Read data |
| dq_oe_o | output | 1 | Data driver enable; 0 means high impedance |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is both software strobes together: the bench raises `sw_store_i` and `sw_recall_i` in one cycle after loading SRAM data that differs from the shadow. It then reads every byte back. Only the store-then-recall order leaves the new SRAM data in place, and the bench also counts two back-to-back transfers. The second pair is an outside pull-down of the busy line in the same cycle as a user write. The bench judges that case by reading the written address afterwards and by seeing a STORE begin.

// File: rtl/nvshadow_pkg.sv
package nvshadow_pkg;

    typedef enum logic {
        OP_STORE  = 1'b0,
        OP_RECALL = 1'b1
    } xfer_op_e;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic wr;
        logic rd;
    } bus_cmd_t;

    // Decode the active-low strobes; 'open' gates the whole access.
    function automatic bus_cmd_t decode_bus(input logic open,
                                            input logic ce_n,
                                            input logic we_n,
                                            input logic oe_n);
        bus_cmd_t c;
        c.wr = open && !ce_n && !we_n;
        c.rd = open && !ce_n && we_n && !oe_n;
        return c;
    endfunction

endpackage

// File: rtl/nvshadow_req_arb.sv
module nvshadow_req_arb
    import nvshadow_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pwr_fail_i,
    input  logic     sw_store_i,
    input  logic     sw_recall_i,
    input  logic     busy_line_i,
    input  logic     self_drive_i,
    input  logic     idle_i,
    output logic     start_o,
    output xfer_op_e op_o,
    output logic     store_pend_o
);

    logic pf_q;
    logic line_q;
    logic pend_store_q;
    logic pend_recall_q;
    logic req_store;
    logic req_recall;
    logic take_store;
    logic take_recall;

    assign req_store  = (pwr_fail_i && !pf_q) || sw_store_i ||
                        (line_q && !busy_line_i && !self_drive_i);
    assign req_recall = sw_recall_i;

    assign start_o     = idle_i && (pend_store_q || pend_recall_q);
    assign op_o        = pend_store_q ? OP_STORE : OP_RECALL;
    assign take_store  = start_o && (op_o == OP_STORE);
    assign take_recall = start_o && (op_o == OP_RECALL);
    assign store_pend_o = pend_store_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pf_q          <= 1'b0;
            line_q        <= 1'b1;
            pend_store_q  <= 1'b0;
            pend_recall_q <= 1'b1;
        end else begin
            pf_q          <= pwr_fail_i;
            line_q        <= busy_line_i;
            pend_store_q  <= (pend_store_q && !take_store) || req_store;
            pend_recall_q <= (pend_recall_q && !take_recall) || req_recall;
        end
    end

endmodule

// File: rtl/nvshadow_xfer_seq.sv
module nvshadow_xfer_seq
    import nvshadow_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  xfer_op_e          op_i,
    output logic              run_o,
    output logic              idle_o,
    output xfer_op_e          op_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    seq_state_e        state_q;
    xfer_op_e          op_q;
    logic [ADDR_W-1:0] cnt_q;
    logic              done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            op_q    <= OP_RECALL;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                SQ_IDLE: begin
                    if (start_i) begin
                        state_q <= SQ_RUN;
                        op_q    <= op_i;
                        cnt_q   <= '0;
                    end
                end
                SQ_RUN: begin
                    if (cnt_q == LAST_ADDR) begin
                        state_q <= SQ_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign run_o  = (state_q == SQ_RUN);
    assign idle_o = (state_q == SQ_IDLE);
    assign op_o   = op_q;
    assign addr_o = cnt_q;
    assign done_o = done_q;

    // R11
    done_after_run_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!run_o && $past(run_o)));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run_o && addr_o != LAST_ADDR) |=>
        (run_o && addr_o == ADDR_W'($past(addr_o) + 1'b1)));

endmodule

// File: rtl/nvshadow_byte_array.sv
module nvshadow_byte_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            cells[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/nvshadow_ram.sv
module nvshadow_ram
    import nvshadow_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_fail_i,
    input  logic              sw_store_i,
    input  logic              sw_recall_i,
    input  logic              busy_n_i,
    output logic              busy_drv_o,
    input  logic              ce_n_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o,
    output logic              done_o
);

    logic              start;
    xfer_op_e          arb_op;
    logic              store_pend;
    logic              run;
    logic              idle;
    xfer_op_e          run_op;
    logic [ADDR_W-1:0] xfer_addr;
    logic              seq_done;
    bus_cmd_t          ucmd;
    logic              sram_we;
    logic [ADDR_W-1:0] sram_waddr;
    logic [DATA_W-1:0] sram_wdata;
    logic [ADDR_W-1:0] sram_raddr;
    logic [DATA_W-1:0] sram_rdata;
    logic              shd_we;
    logic [DATA_W-1:0] shd_rdata;

    nvshadow_req_arb u_arb (
        .clk          (clk),
        .rst          (rst),
        .pwr_fail_i   (pwr_fail_i),
        .sw_store_i   (sw_store_i),
        .sw_recall_i  (sw_recall_i),
        .busy_line_i  (busy_n_i),
        .self_drive_i (run),
        .idle_i       (idle),
        .start_o      (start),
        .op_o         (arb_op),
        .store_pend_o (store_pend)
    );

    nvshadow_xfer_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .op_i    (arb_op),
        .run_o   (run),
        .idle_o  (idle),
        .op_o    (run_op),
        .addr_o  (xfer_addr),
        .done_o  (seq_done)
    );

    // User access is open only when idle and nobody holds the busy line low.
    assign ucmd = decode_bus(idle && busy_n_i, ce_n_i, we_n_i, oe_n_i);

    assign sram_we    = (run && run_op == OP_RECALL) || ucmd.wr;
    assign sram_waddr = run ? xfer_addr : addr_i;
    assign sram_wdata = run ? shd_rdata : dq_i;
    assign sram_raddr = run ? xfer_addr : addr_i;
    assign shd_we     = run && run_op == OP_STORE;

    nvshadow_byte_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sram (
        .clk     (clk),
        .we_i    (sram_we),
        .waddr_i (sram_waddr),
        .wdata_i (sram_wdata),
        .raddr_i (sram_raddr),
        .rdata_o (sram_rdata)
    );

    nvshadow_byte_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shadow (
        .clk     (clk),
        .we_i    (shd_we),
        .waddr_i (xfer_addr),
        .wdata_i (sram_rdata),
        .raddr_i (xfer_addr),
        .rdata_o (shd_rdata)
    );

    assign busy_drv_o = run;
    assign dq_oe_o    = ucmd.rd;
    assign dq_o       = ucmd.rd ? sram_rdata : '0;
    assign done_o     = seq_done;

    // R8
    xfer_quiet_dq_chk: assert property (@(posedge clk) disable iff (rst)
        busy_drv_o |-> !dq_oe_o);

    // R8
    xfer_no_user_wr_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> !ucmd.wr);

    // R9
    store_chain_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_done && store_pend) |=> busy_drv_o);

endmodule

// File: tb/nvshadow_ram_test.sv
module nvshadow_ram_test;

    localparam int AW = 10;
    localparam int DW = 8;
    localparam int N  = 1 << AW;

    typedef struct {
        logic [DW-1:0] v;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwr_fail = 1'b0;
    logic          sw_store = 1'b0;
    logic          sw_recall = 1'b0;
    logic          ext_pull = 1'b0;
    logic          busy_drv;
    logic          busy_line;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;
    logic          done;

    int   checks = 0;
    int   failures = 0;
    bit   mon_en = 1'b0;
    bit   finished = 1'b0;
    int   cyc = 0;
    exp_t exp_q[$];

    // Open-drain busy line: low if either side pulls it.
    assign busy_line = !(busy_drv || ext_pull);

    always #4 clk = ~clk;

    nvshadow_ram #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk         (clk),
        .rst         (rst),
        .pwr_fail_i  (pwr_fail),
        .sw_store_i  (sw_store),
        .sw_recall_i (sw_recall),
        .busy_n_i    (busy_line),
        .busy_drv_o  (busy_drv),
        .ce_n_i      (ce_n),
        .we_n_i      (we_n),
        .oe_n_i      (oe_n),
        .addr_i      (addr),
        .dq_i        (dq_in),
        .dq_o        (dq_out),
        .dq_oe_o     (dq_oe),
        .done_o      (done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a, input logic [DW-1:0] s);
        return DW'(a * 13) ^ DW'(a >> 4) ^ s;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_idle();
        tick();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        mon_en = 1'b0;
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        tick();
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        addr = AW'(a); dq_in = d;
    endtask

    // Driver: put a read on the bus and queue the byte the monitor must see.
    task automatic rd(input int a, input logic [DW-1:0] e, input string tag);
        exp_t it;
        tick();
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
        addr = AW'(a);
        it.v = e; it.tag = tag;
        exp_q.push_back(it);
        mon_en = 1'b1;
    endtask

    task automatic fill(input logic [DW-1:0] s);
        for (int a = 0; a < N; a++) wr(a, pat(a, s));
        bus_idle();
    endtask

    task automatic read_all(input logic [DW-1:0] s, input string tag);
        for (int a = 0; a < N; a++) rd(a, pat(a, s), tag);
        bus_idle();
    endtask

    // Monitor: pop and compare on the falling edge.
    always @(negedge clk) begin
        if (mon_en) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 read with empty scoreboard", int'(dq_out), 0);
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                chk(dq_oe === 1'b1 && dq_out === it.v, it.tag,
                    int'({dq_oe, dq_out}), int'({1'b1, it.v}));
            end
        end
    end

    // Measure one transfer: length, busy line held, done pulse, release.
    task automatic xfer(input string tag, input bit at_neg);
        int w = 0;
        int len = 0;
        bit line_ok = 1'b1;
        if (!at_neg) @(negedge clk);
        while (!busy_drv && w < 8) begin
            @(negedge clk);
            w++;
        end
        chk(busy_drv === 1'b1, {tag, " transfer start"}, int'(busy_drv), 1);
        while (busy_drv && len < N + 16) begin
            if (busy_line !== 1'b0) line_ok = 1'b0;
            len++;
            @(negedge clk);
        end
        chk(len == N, {tag, " R4 transfer length"}, len, N);
        chk(line_ok, {tag, " R7 busy line low throughout"}, int'(line_ok), 1);
        chk(done === 1'b1, {tag, " R11 done after last byte"}, int'(done), 1);
        if (!ext_pull) chk(busy_line === 1'b1, {tag, " R7 line released"}, int'(busy_line), 1);
        @(negedge clk);
        chk(done === 1'b0, {tag, " R11 done one cycle"}, int'(done), 0);
    endtask

    task automatic pulse_store();
        tick(); sw_store = 1'b1;
        tick(); sw_store = 1'b0;
    endtask

    task automatic pulse_recall();
        tick(); sw_recall = 1'b1;
        tick(); sw_recall = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: quiet while in reset
        repeat (4) tick();
        @(negedge clk);
        chk(busy_drv === 1'b0, "R1 busy drive in reset", int'(busy_drv), 0);
        chk(dq_oe === 1'b0, "R1 dq_oe in reset", int'(dq_oe), 0);
        chk(done === 1'b0, "R1 done in reset", int'(done), 0);
        tick();
        rst = 1'b0;
        // R1: power-up RECALL
        xfer("R1 power-up recall", 1'b0);

        // R2: write and read back
        fill(8'h3C);
        read_all(8'h3C, "R2 readback");

        // R3: output enable or select high keeps the driver off
        tick(); ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; addr = AW'(3);
        @(negedge clk);
        chk(dq_oe === 1'b0, "R3 oe_n high", int'(dq_oe), 0);
        tick(); ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk);
        chk(dq_oe === 1'b0, "R3 ce_n high", int'(dq_oe), 0);
        bus_idle();

        // R6 software STORE, with R8 access attempts mid-transfer
        pulse_store();
        fork
            xfer("R6 sw store", 1'b0);
            begin
                repeat (30) tick();
                ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = AW'(7); dq_in = 8'hFF;
                tick();
                we_n = 1'b1; oe_n = 1'b0;
                @(negedge clk);
                chk(dq_oe === 1'b0, "R8 dq_oe during transfer", int'(dq_oe), 0);
                tick();
                ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
            end
        join
        rd(7, pat(7, 8'h3C), "R8 write ignored during transfer");
        bus_idle();

        // R5: RECALL overwrites newer user data
        fill(8'hA5);
        pulse_recall();
        xfer("R5 sw recall", 1'b0);
        read_all(8'h3C, "R5 recall restores stored image");

        // R6: power-fail rising edge starts a STORE
        fill(8'h5A);
        tick(); pwr_fail = 1'b1;
        xfer("R6 power-fail store", 1'b0);
        tick(); pwr_fail = 1'b0;
        fill(8'h11);
        pulse_recall();
        xfer("R6 recall after power-fail store", 1'b0);
        read_all(8'h5A, "R6 power-fail store captured");

        // R9: STORE requested during RECALL runs right after it
        pulse_recall();
        fork
            xfer("R9 recall", 1'b0);
            begin
                repeat (40) tick();
                sw_store = 1'b1;
                tick();
                sw_store = 1'b0;
            end
        join
        chk(busy_drv === 1'b1, "R9 store starts right after done", int'(busy_drv), 1);
        xfer("R9 chained store", 1'b1);

        // R10: both strobes in one cycle, STORE first
        fill(8'h99);
        tick(); sw_store = 1'b1; sw_recall = 1'b1;
        tick(); sw_store = 1'b0; sw_recall = 1'b0;
        xfer("R10 first transfer", 1'b0);
        chk(busy_drv === 1'b1, "R10 second transfer follows", int'(busy_drv), 1);
        xfer("R10 second transfer", 1'b1);
        read_all(8'h99, "R10 store ran before recall");

        // R12 + R6: outside pull-down together with a user write
        tick();
        ext_pull = 1'b1;
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = AW'(5); dq_in = 8'h00;
        bus_idle();
        xfer("R6 busy-line store", 1'b0);
        tick(); ext_pull = 1'b0;
        tick();
        rd(5, pat(5, 8'h99), "R12 write ignored while line held low");
        bus_idle();
        fill(8'h42);
        pulse_recall();
        xfer("R6 recall after busy-line store", 1'b0);
        read_all(8'h99, "R6 busy-line store captured");

        repeat (4) tick();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule